// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects interrupt requests from eight sources and presents one of them to a processor core. The sources are six internal or external request lines and two extra active-low external pins. It returns a request line and the vector address of the chosen source. Each source has its own enable bit and priority bit. A global enable gates all eight sources. Among sources of equal priority, a fixed polling order picks the winner.

The controller keeps track of which priority levels are currently being serviced. A pulse on the acknowledge input accepts the request that is on offer and opens a handler at that source's level. A pulse on the return input closes the most recently opened level. A high-priority request can interrupt a low-priority handler. Nothing can interrupt a high-priority handler.

The two extra pins are controlled by an 8-bit control register that software can write and read back. For each pin the register holds a trigger-type bit, a pending flag, an enable bit and a priority bit. In edge mode the flag is set by hardware on a synchronized falling edge and cleared when that source is acknowledged. In level mode the flag simply follows the inverted pin.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source k (0 = ext0, 1 = timer0, 2 = ext1, 3 = timer1, 4 = serial, 5 = timer2, 6 = extra pin A, 7 = extra pin B) is presented on `vec_o` as 03h + 8·k, and `src_id_o` carries k. Both outputs read 0 when `irq_o` is low.
- R2: When several sources of the same priority are pending and enabled, the one with the lowest index k is presented.
- R3: A pending, enabled high-priority source (priority bit 1) is presented ahead of any low-priority source, regardless of index.
- R4: While only a low-priority handler is active, a low-priority request is held back. A high-priority request is presented, and acknowledging it opens the high level.
- R5: While a high-priority handler is active, `irq_o` stays low whatever is pending.
- R6: A source whose enable bit is 0 is never presented. With `glb_en_i` low, `irq_o` stays low.
- R7: The control register reads back on `xctl_q_o` with this bit layout: bit 7 prio B, bit 6 enable B, bit 5 flag B, bit 4 type B, bit 3 prio A, bit 2 enable A, bit 1 flag A, bit 0 type A. A write loads every non-flag bit. It also loads the flag bits of a pin that is in edge mode.
- R8: With type = 1 (edge mode), a pin going from high to low, after two synchronizer stages, sets that pin's flag. A rising edge, or a pin that stays low, sets nothing.
- R9: In edge mode, acknowledging that pin's source clears its flag.
- R10: With type = 0 (level mode), the flag follows the inverted synchronized pin, and acknowledging the source does not clear it.
- R11: A return pulse closes the high level if it is active, and otherwise closes the low level. `act_lvl_o` shows bit 1 = high active and bit 0 = low active.
- R12: After reset, `irq_o` is 0, `xctl_q_o` is 00h and `act_lvl_o` is 0.
- R13: An acknowledge pulse while `irq_o` is low changes no active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en_i | input | 1 | Global enable for all sources |
| req_i | input | 6 | Pending request of sources 0..5 |
| en_i | input | 6 | Enable bits of sources 0..5 |
| prio_i | input | 6 | Priority bits of sources 0..5 (1 = high) |
| xpin_n_i | input | 2 | Extra external pins, active low (bit 0 = pin A, bit 1 = pin B) |
| xctl_we_i | input | 1 | Write strobe for the control register |
| xctl_wdata_i | input | 8 | Write data for the control register |
| xctl_q_o | output | 8 | Control register contents |
| ack_i | input | 1 | Core accepts the presented request |
| reti_i | input | 1 | Core leaves the current handler |
| irq_o | output | 1 | Request to the core |
| vec_o | output | 8 | Vector address of the presented source |
| src_id_o | output | 3 | Index of the presented source |
| act_lvl_o | output | 2 | Active levels: bit 1 high, bit 0 low |

## Verification
If the active-level state is wrong, it shows up at once as a missing or spurious `irq_o`, or as the wrong `act_lvl_o` value in the cycle after an acknowledge or return. If an edge flag is wrong, it shows on `xctl_q_o` three clock edges after the pin changes, or one edge after an acknowledge, so the bench samples the register at those points. A wrong polling or priority choice shows up with no delay as the wrong vector, so each pattern of pending sources is checked against a vector computed as 03h + 8·k.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC     = 8;
  localparam int unsigned NBASE    = 6;
  localparam int unsigned NXPIN    = NSRC - NBASE;
  localparam int unsigned IDW      = $clog2(NSRC);
  localparam int unsigned VW       = 8;
  localparam int unsigned VEC_BASE = 3;
  localparam int unsigned VEC_STEP = 8;
  localparam int unsigned FLDW     = 4;
  localparam int unsigned CTLW     = FLDW * NXPIN;

  // position of each bit inside one pin's control nibble
  localparam int unsigned F_TYPE = 0;
  localparam int unsigned F_FLAG = 1;
  localparam int unsigned F_EN   = 2;
  localparam int unsigned F_PRIO = 3;

  typedef enum logic [IDW-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_TMR2 = 3'd5,
    SRC_XPA  = 3'd6,
    SRC_XPB  = 3'd7
  } src_e;

  function automatic logic [VW-1:0] vec_of(input logic [IDW-1:0] id);
    return VW'(VEC_BASE + VEC_STEP * int'(id));
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/irq_xsync.sv
module irq_xsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic low_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q, prev_d;

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], pin_n_i};
    prev_d = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  assign low_o  = ~sh_q[STAGES-1];
  assign fall_o = prev_q & ~sh_q[STAGES-1];

  // R8
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/irq_xctl.sv
module irq_xctl
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [CTLW-1:0] wdata_i,
  input  logic [NXPIN-1:0] fall_i,
  input  logic [NXPIN-1:0] low_i,
  input  logic [NXPIN-1:0] clr_i,
  output logic [CTLW-1:0] ctl_o
);
  logic [CTLW-1:0] ctl_q, ctl_d;

  for (genvar g = 0; g < NXPIN; g++) begin : g_pin
    localparam int unsigned B = FLDW * g;
    logic [FLDW-1:0] fld_d;
    logic            edge_mode;

    assign edge_mode = ctl_q[B+F_TYPE];

    always_comb begin
      fld_d = ctl_q[B +: FLDW];
      if (we_i) begin
        fld_d[F_TYPE] = wdata_i[B+F_TYPE];
        fld_d[F_EN]   = wdata_i[B+F_EN];
        fld_d[F_PRIO] = wdata_i[B+F_PRIO];
      end
      if (edge_mode) begin
        if (fall_i[g])      fld_d[F_FLAG] = 1'b1;
        else if (clr_i[g])  fld_d[F_FLAG] = 1'b0;
        else if (we_i)      fld_d[F_FLAG] = wdata_i[B+F_FLAG];
      end else begin
        fld_d[F_FLAG] = low_i[g];
      end
    end

    assign ctl_d[B +: FLDW] = fld_d;

    // R9
    edge_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && clr_i[g] && !fall_i[g]) |=> !ctl_q[B+F_FLAG]);
    // R10
    lvl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_mode && clr_i[g] && low_i[g]) |=> ctl_q[B+F_FLAG]);
    // R8
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && fall_i[g]) |=> ctl_q[B+F_FLAG]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] prio_i,
  input  logic            glb_en_i,
  input  logic            act_hi_i,
  input  logic            act_lo_i,
  output logic            valid_o,
  output logic [IDW-1:0]  id_o,
  output logic            hi_o
);
  logic [NSRC-1:0] elig, hi_set, lo_set, pick;

  always_comb begin
    elig   = pend_i & en_i & {NSRC{glb_en_i}};
    hi_set = elig & prio_i;
    lo_set = elig & ~prio_i;
    if (act_hi_i)      pick = '0;
    else if (act_lo_i) pick = hi_set;
    else               pick = (|hi_set) ? hi_set : lo_set;
  end

  always_comb begin
    id_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pick[i]) id_o = IDW'(i);
    end
  end

  assign valid_o = |pick;
  assign hi_o    = prio_i[id_o];

  // R3
  hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && |hi_set) |-> hi_o);
  // R5
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_hi_i |-> !valid_o);
  // R6
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (glb_en_i && en_i[id_o] && pend_i[id_o]));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en_i,
  input  logic [NBASE-1:0] req_i,
  input  logic [NBASE-1:0] en_i,
  input  logic [NBASE-1:0] prio_i,
  input  logic [NXPIN-1:0] xpin_n_i,
  input  logic             xctl_we_i,
  input  logic [CTLW-1:0]  xctl_wdata_i,
  output logic [CTLW-1:0]  xctl_q_o,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             irq_o,
  output logic [VW-1:0]    vec_o,
  output logic [IDW-1:0]   src_id_o,
  output logic [1:0]       act_lvl_o
);
  logic            rst_n_s;
  logic [NXPIN-1:0] x_low, x_fall, x_clr;
  logic [CTLW-1:0] ctl;
  logic [NSRC-1:0] pend, en_all, prio_all;
  logic            valid, sel_hi;
  logic [IDW-1:0]  sel_id;
  logic            act_hi_q, act_hi_d, act_lo_q, act_lo_d;
  logic            take;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  for (genvar g = 0; g < NXPIN; g++) begin : g_xs
    irq_xsync #(.STAGES(SYNC_STAGES)) u_xs (
      .clk(clk), .rst_n(rst_n_s), .pin_n_i(xpin_n_i[g]),
      .low_o(x_low[g]), .fall_o(x_fall[g])
    );
    assign pend[NBASE+g]     = ctl[FLDW*g+F_FLAG];
    assign en_all[NBASE+g]   = ctl[FLDW*g+F_EN];
    assign prio_all[NBASE+g] = ctl[FLDW*g+F_PRIO];
    assign x_clr[g]          = take && (sel_id == IDW'(NBASE + g));
  end

  assign pend[NBASE-1:0]     = req_i;
  assign en_all[NBASE-1:0]   = en_i;
  assign prio_all[NBASE-1:0] = prio_i;

  irq_xctl u_xctl (
    .clk(clk), .rst_n(rst_n_s), .we_i(xctl_we_i), .wdata_i(xctl_wdata_i),
    .fall_i(x_fall), .low_i(x_low), .clr_i(x_clr), .ctl_o(ctl)
  );

  irq_arb u_arb (
    .clk(clk), .rst_n(rst_n_s), .pend_i(pend), .en_i(en_all),
    .prio_i(prio_all), .glb_en_i(glb_en_i), .act_hi_i(act_hi_q),
    .act_lo_i(act_lo_q), .valid_o(valid), .id_o(sel_id), .hi_o(sel_hi)
  );

  assign take = ack_i & valid;

  always_comb begin
    act_hi_d = act_hi_q;
    act_lo_d = act_lo_q;
    if (reti_i) begin
      if (act_hi_q) act_hi_d = 1'b0;
      else          act_lo_d = 1'b0;
    end
    if (take) begin
      if (sel_hi) act_hi_d = 1'b1;
      else        act_lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      act_hi_q <= 1'b0;
      act_lo_q <= 1'b0;
    end else begin
      act_hi_q <= act_hi_d;
      act_lo_q <= act_lo_d;
    end
  end

  assign irq_o     = valid;
  assign src_id_o  = valid ? sel_id : '0;
  assign vec_o     = valid ? vec_of(sel_id) : '0;
  assign act_lvl_o = {act_hi_q, act_lo_q};
  assign xctl_q_o  = ctl;

  // R1
  vec_map_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o |-> (vec_o[2:0] == 3'b011 && vec_o[7:3] == 5'(src_id_o)));
  // R4
  preempt_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ack_i && irq_o && act_lo_q && !reti_i) |=> act_hi_q);
  // R11
  reti_pop_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reti_i && !ack_i && act_hi_q) |=> (!act_hi_q && act_lo_q == $past(act_lo_q)));
  // R13
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ack_i && !irq_o && !reti_i) |=> $stable(act_lvl_o));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       glb_en_i;
  logic [5:0] req_i, en_i, prio_i;
  logic [1:0] xpin_n_i;
  logic       xctl_we_i;
  logic [7:0] xctl_wdata_i, xctl_q_o;
  logic       ack_i, reti_i, irq_o;
  logic [7:0] vec_o;
  logic [2:0] src_id_o;
  logic [1:0] act_lvl_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en_i), .req_i(req_i),
    .en_i(en_i), .prio_i(prio_i), .xpin_n_i(xpin_n_i),
    .xctl_we_i(xctl_we_i), .xctl_wdata_i(xctl_wdata_i), .xctl_q_o(xctl_q_o),
    .ack_i(ack_i), .reti_i(reti_i), .irq_o(irq_o), .vec_o(vec_o),
    .src_id_o(src_id_o), .act_lvl_o(act_lvl_o)
  );

  function automatic logic [7:0] exp_vec(input int k);
    return 8'(3 + 8 * k);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_ack();
    ack_i = 1'b1; tick(1); ack_i = 1'b0; settle();
  endtask

  task automatic do_reti();
    reti_i = 1'b1; tick(1); reti_i = 1'b0; settle();
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    xctl_we_i = 1'b1; xctl_wdata_i = v; tick(1); xctl_we_i = 1'b0; settle();
  endtask

  task automatic t_reset();
    check("R12 irq after reset", 32'(irq_o), 0);
    check("R12 xctl after reset", 32'(xctl_q_o), 0);
    check("R12 act after reset", 32'(act_lvl_o), 0);
  endtask

  task automatic t_vectors();
    for (int k = 0; k < 6; k++) begin
      req_i = 6'(1 << k); settle();
      check("R1 base vector", 32'(vec_o), 32'(exp_vec(k)));
      check("R1 base id", 32'(src_id_o), 32'(k));
    end
    req_i = '0; settle();
    check("R1 idle vector zero", 32'(vec_o), 0);
  endtask

  task automatic t_order();
    req_i = 6'h3F; settle();
    check("R2 all pending", 32'(vec_o), 32'(exp_vec(0)));
    req_i = 6'b101010; settle();
    check("R2 odd pending", 32'(vec_o), 32'(exp_vec(1)));
    req_i = 6'b110000; settle();
    check("R2 top pair", 32'(vec_o), 32'(exp_vec(4)));
    req_i = '0;
  endtask

  task automatic t_prio();
    req_i = 6'b010001; prio_i = 6'b010000; settle();
    check("R3 high beats low index", 32'(vec_o), 32'(exp_vec(4)));
    req_i = '0; prio_i = '0; settle();
  endtask

  task automatic t_gate();
    req_i = 6'h3F; glb_en_i = 1'b0; settle();
    check("R6 global off", 32'(irq_o), 0);
    glb_en_i = 1'b1; en_i = 6'b111110; req_i = 6'b000011; settle();
    check("R6 source disabled", 32'(vec_o), 32'(exp_vec(1)));
    en_i = 6'h3F; req_i = '0; settle();
  endtask

  task automatic t_nest();
    req_i = 6'b000010; prio_i = '0; settle();
    do_ack();
    check("R4 low level open", 32'(act_lvl_o), 1);
    check("R4 low held during low", 32'(irq_o), 0);
    req_i = 6'b100010; prio_i = 6'b100000; settle();
    check("R4 high preempts", 32'(vec_o), 32'(exp_vec(5)));
    do_ack();
    check("R4 high level open", 32'(act_lvl_o), 3);
    req_i = 6'b100011; prio_i = 6'b100001; settle();
    check("R5 nothing during high", 32'(irq_o), 0);
    do_reti();
    check("R11 high closed first", 32'(act_lvl_o), 1);
    check("R11 high offered again", 32'(irq_o), 1);
    do_reti();
    check("R11 low closed", 32'(act_lvl_o), 0);
    req_i = '0; prio_i = '0; settle();
  endtask

  task automatic t_ack_idle();
    req_i = '0; settle();
    do_ack();
    check("R13 ack while idle", 32'(act_lvl_o), 0);
  endtask

  task automatic t_level();
    wr_ctl(8'h04);
    xpin_n_i[0] = 1'b0; tick(4); settle();
    check("R10 level flag A", 32'(xctl_q_o), 32'h06);
    check("R1 pin A vector", 32'(vec_o), 32'(exp_vec(6)));
    xpin_n_i[0] = 1'b1; tick(4); settle();
    check("R10 level flag A released", 32'(xctl_q_o), 32'h04);
    wr_ctl(8'h40);
    xpin_n_i[1] = 1'b0; tick(4); settle();
    check("R10 level flag B", 32'(xctl_q_o), 32'h60);
    check("R1 pin B vector", 32'(vec_o), 32'(exp_vec(7)));
    do_ack();
    check("R10 ack keeps level flag", 32'(xctl_q_o), 32'h60);
    do_reti();
    xpin_n_i[1] = 1'b1; tick(4); settle();
    wr_ctl(8'h00);
  endtask

  task automatic t_edge();
    wr_ctl(8'h05);
    xpin_n_i[0] = 1'b0; tick(4); settle();
    check("R8 falling edge sets flag", 32'(xctl_q_o), 32'h07);
    check("R8 edge source offered", 32'(vec_o), 32'(exp_vec(6)));
    do_ack();
    check("R9 ack clears edge flag", 32'(xctl_q_o), 32'h05);
    do_reti();
    tick(4); settle();
    check("R8 steady low no set", 32'(xctl_q_o), 32'h05);
    xpin_n_i[0] = 1'b1; tick(4); settle();
    check("R8 rising edge no set", 32'(xctl_q_o), 32'h05);
    wr_ctl(8'h00);
  endtask

  task automatic t_layout();
    wr_ctl(8'h99);
    check("R7 readback 99", 32'(xctl_q_o), 32'h99);
    check("R7 disabled no irq", 32'(irq_o), 0);
    wr_ctl(8'h77);
    check("R7 readback 77", 32'(xctl_q_o), 32'h77);
    check("R7 pin A before B", 32'(vec_o), 32'(exp_vec(6)));
    do_ack();
    check("R9 flag A bit 1 cleared", 32'(xctl_q_o), 32'h75);
    do_reti();
    check("R7 pin B next", 32'(vec_o), 32'(exp_vec(7)));
    do_ack();
    check("R9 flag B bit 5 cleared", 32'(xctl_q_o), 32'h55);
    do_reti();
    wr_ctl(8'hF7);
    check("R3 pin B high priority", 32'(vec_o), 32'(exp_vec(7)));
    wr_ctl(8'h00);
  endtask

  initial begin
    rst_n = 1'b0; glb_en_i = 1'b1; req_i = '0; en_i = 6'h3F; prio_i = '0;
    xpin_n_i = 2'b11; xctl_we_i = 1'b0; xctl_wdata_i = '0;
    ack_i = 1'b0; reti_i = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4); settle();
    t_reset();
    t_vectors();
    t_order();
    t_prio();
    t_gate();
    t_nest();
    t_ack_idle();
    t_level();
    t_edge();
    t_layout();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule